// File: doc/BRIEF.md
# Receive Clock Idle Gating

This block saves power on a 100 Mb/s media-independent receive interface by stopping the receive clock between frames. It runs in the recovered receive clock domain. It takes an internal, early data-valid indication and its nibble, and it produces a registered clock-enable that qualifies the receive clock. It also produces the data-valid and data, delayed so that the enable always leads them.

When gating is in force and nothing is being received, the enable is held low. A frame is seen on the early indication one cycle before it appears at the outputs. That lookahead lets the enable rise exactly one cycle before the output data-valid. After the output data-valid falls, the enable stays high for a fixed hangover of 64 cycles and then drops.

Gating is in force only when all of the following hold:

- the enable bit is set;
- the speed input selects 100 Mb/s;
- loopback is off;
- the coding-bypass mode is off.

In every other case the clock runs all the time.

Top module: `rxclk_idle_gate`

## Requirements
- R1: With `speed_100` = 0 (10 Mb/s), `clk_en` is 1 in every cycle after the cycle in which that speed was applied, whatever the data activity.
- R2: With gating in force (`gate_en` = 1, `speed_100` = 1, `loopback` = 0, `pcs_bypass` = 0) and no receive activity for more than the hangover, `clk_en` is 0.
- R3: With gating in force, `clk_en` rises exactly one cycle before `rx_dv` rises, and it is 1 in every cycle where `rx_dv` is 1.
- R4: After `rx_dv` falls, `clk_en` stays 1 for exactly HANG_CYCLES (default 64) cycles in which `rx_dv` is 0. It is 0 in the next cycle unless new activity is seen.
- R5: With `loopback` = 1, `clk_en` is 1 from the next cycle on.
- R6: While reset is held and directly after it, `clk_en` = 1, `rx_dv` = 0 and `rx_data` = 0.
- R7: With `pcs_bypass` = 1, `clk_en` is 1 from the next cycle on.
- R8: `rx_dv` and `rx_data` equal `early_dv` and `early_data` as they were two clock edges earlier: one stage of lookahead plus one output stage.
- R9: If `rx_dv` rises again within the hangover, the hangover restarts and `clk_en` shows no low cycle between the two frames.
- R10: Clearing `gate_en` while the clock is stopped makes `clk_en` 1 in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running recovered receive clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| early_dv | input | 1 | Early receive data-valid, one cycle ahead of the lookahead stage |
| early_data | input | DATA_W | Early receive nibble |
| gate_en | input | 1 | Idle clock gating enable (1 = gating allowed) |
| speed_100 | input | 1 | Speed mode: 1 = 100 Mb/s, 0 = 10 Mb/s |
| loopback | input | 1 | Loopback mode active; forces the clock on |
| pcs_bypass | input | 1 | Coding-bypass mode active; forces the clock on |
| clk_en | output | 1 | Registered enable that qualifies the receive clock |
| rx_dv | output | 1 | Data-valid aligned with the qualified clock |
| rx_data | output | DATA_W | Data aligned with `rx_dv` |

## Verification
The assertions assume that `early_dv`, `early_data` and the four mode inputs are synchronous to `clk`. Each of them is sampled once per edge. They also assume that the mode inputs take effect from the edge that samples them, with no requirement that they stay still during a frame. The stimulus changes every input only at the falling edge, half a cycle away from the capture edge. It also switches modes only while no frame is in flight, except for the deliberate reassertion inside the hangover. The assertions that look back one or two cycles are held off by a count of edges since reset release. They therefore never compare against values captured while reset was asserted.

// File: rtl/rxg_pkg.sv
package rxg_pkg;
    parameter int unsigned RXG_DATA_W_DEF = 4;
    parameter int unsigned RXG_HANG_DEF   = 64;

    function automatic logic rxg_gating_allowed(
        input logic en_bit,
        input logic fast_mode,
        input logic lb_mode,
        input logic bypass_mode
    );
        return en_bit & fast_mode & ~lb_mode & ~bypass_mode;
    endfunction
endpackage

// File: rtl/rxg_lookahead.sv
module rxg_lookahead #(
    parameter int unsigned DATA_W = rxg_pkg::RXG_DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_dv,
    input  logic [DATA_W-1:0] in_data,
    output logic              ahead_dv,
    output logic              out_dv,
    output logic [DATA_W-1:0] out_data
);
    typedef struct packed {
        logic              stg_dv;
        logic [DATA_W-1:0] stg_data;
        logic              out_dv;
        logic [DATA_W-1:0] out_data;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    always_comb begin
        pipe_d          = pipe_q;
        pipe_d.stg_dv   = in_dv;
        pipe_d.stg_data = in_data;
        pipe_d.out_dv   = pipe_q.stg_dv;
        pipe_d.out_data = pipe_q.stg_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign ahead_dv = pipe_q.stg_dv;
    assign out_dv   = pipe_q.out_dv;
    assign out_data = pipe_q.out_data;
endmodule

// File: rtl/rxg_hangover.sv
module rxg_hangover #(
    parameter int unsigned HANG = rxg_pkg::RXG_HANG_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic next_dv,
    output logic hang_open
);
    localparam int unsigned CNT_W = $clog2(HANG + 2);
    localparam logic [CNT_W-1:0] HANG_V = CNT_W'(HANG);
    localparam logic [CNT_W-1:0] SAT_V  = CNT_W'(HANG + 1);

    typedef struct packed {
        logic [CNT_W-1:0] quiet;
    } hang_t;

    hang_t hg_d, hg_q;

    always_comb begin
        hg_d = hg_q;
        if (next_dv) begin
            hg_d.quiet = '0;
        end else if (hg_q.quiet < SAT_V) begin
            hg_d.quiet = hg_q.quiet + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hg_q.quiet <= SAT_V;
        end else begin
            hg_q <= hg_d;
        end
    end

    assign hang_open = (hg_d.quiet <= HANG_V);
endmodule

// File: rtl/rxg_enable_reg.sv
module rxg_enable_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_active,
    input  logic look_dv,
    input  logic hang_open,
    output logic clk_en
);
    typedef struct packed {
        logic en;
    } en_t;

    en_t en_d, en_q;

    always_comb begin
        en_d    = en_q;
        en_d.en = ~gate_active | look_dv | hang_open;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q.en <= 1'b1;
        end else begin
            en_q <= en_d;
        end
    end

    assign clk_en = en_q.en;
endmodule

// File: rtl/rxclk_idle_gate.sv
module rxclk_idle_gate #(
    parameter int unsigned DATA_W      = rxg_pkg::RXG_DATA_W_DEF,
    parameter int unsigned HANG_CYCLES = rxg_pkg::RXG_HANG_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              early_dv,
    input  logic [DATA_W-1:0] early_data,
    input  logic              gate_en,
    input  logic              speed_100,
    input  logic              loopback,
    input  logic              pcs_bypass,
    output logic              clk_en,
    output logic              rx_dv,
    output logic [DATA_W-1:0] rx_data
);
    logic gate_active;
    logic ahead_dv;
    logic hang_open;

    assign gate_active = rxg_pkg::rxg_gating_allowed(gate_en, speed_100, loopback, pcs_bypass);

    rxg_lookahead #(.DATA_W(DATA_W)) u_look (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_dv    (early_dv),
        .in_data  (early_data),
        .ahead_dv (ahead_dv),
        .out_dv   (rx_dv),
        .out_data (rx_data)
    );

    rxg_hangover #(.HANG(HANG_CYCLES)) u_hang (
        .clk       (clk),
        .rst_n     (rst_n),
        .next_dv   (ahead_dv),
        .hang_open (hang_open)
    );

    rxg_enable_reg u_en (
        .clk         (clk),
        .rst_n       (rst_n),
        .gate_active (gate_active),
        .look_dv     (early_dv),
        .hang_open   (hang_open),
        .clk_en      (clk_en)
    );
endmodule

// File: rtl/rxclk_idle_gate_chk.sv
module rxclk_idle_gate_chk #(
    parameter int unsigned HANG = 64
) (
    input logic clk,
    input logic rst_n,
    input logic early_dv,
    input logic gate_en,
    input logic speed_100,
    input logic loopback,
    input logic pcs_bypass,
    input logic clk_en,
    input logic rx_dv
);
    localparam int unsigned IW = $clog2(HANG + 2);
    localparam logic [IW-1:0] IMAX = IW'(HANG + 1);
    localparam logic [IW-1:0] IHANG = IW'(HANG);

    logic [1:0]    age_q;
    logic          act_q;
    logic [IW-1:0] idle_q;
    logic [IW-1:0] idle_now;

    always_comb begin
        if (rx_dv) begin
            idle_now = '0;
        end else if (idle_q < IMAX) begin
            idle_now = idle_q + 1'b1;
        end else begin
            idle_now = IMAX;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q  <= '0;
            act_q  <= 1'b0;
            idle_q <= IMAX;
        end else begin
            if (age_q != 2'd3) age_q <= age_q + 2'd1;
            act_q  <= gate_en && speed_100 && !loopback && !pcs_bypass;
            idle_q <= idle_now;
        end
    end

    assert_free_run_10m_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q != 2'd0 && $past(!speed_100)) |-> clk_en);

    assert_idle_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2 && $past(act_q && idle_now > IHANG) && !rx_dv) |-> !$past(clk_en));

    assert_run_with_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_dv |-> clk_en);

    assert_lead_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q != 2'd0 && $rose(rx_dv)) |-> $past(clk_en));

    assert_hangover_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_now >= 1 && idle_now <= IHANG) |-> clk_en);

    assert_loopback_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q != 2'd0 && $past(loopback)) |-> clk_en);

    assert_bypass_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q != 2'd0 && $past(pcs_bypass)) |-> clk_en);

    assert_dv_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2) |-> (rx_dv == $past(early_dv, 2)));

    assert_disable_run_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q != 2'd0 && $past(!gate_en)) |-> clk_en);
endmodule

bind rxclk_idle_gate rxclk_idle_gate_chk #(.HANG(HANG_CYCLES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .early_dv   (early_dv),
    .gate_en    (gate_en),
    .speed_100  (speed_100),
    .loopback   (loopback),
    .pcs_bypass (pcs_bypass),
    .clk_en     (clk_en),
    .rx_dv      (rx_dv)
);

// File: tb/rxclk_idle_gate_test.sv
`timescale 1ns/1ps
module rxclk_idle_gate_test;
    localparam int DW   = 4;
    localparam int HANG = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          early_dv = 1'b0;
    logic [DW-1:0] early_data = '0;
    logic          gate_en = 1'b0;
    logic          speed_100 = 1'b0;
    logic          loopback = 1'b0;
    logic          pcs_bypass = 1'b0;
    logic          clk_en;
    logic          rx_dv;
    logic [DW-1:0] rx_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    string phase = "R6";

    bit            m_dv_q[$];
    logic [DW-1:0] m_dq[$];
    bit            m_rx_dv;
    logic [DW-1:0] m_rx_data;
    bit            m_en;
    int            m_quiet;

    always #2 clk = ~clk;

    rxclk_idle_gate #(.DATA_W(DW), .HANG_CYCLES(HANG)) uut (
        .clk(clk), .rst_n(rst_n), .early_dv(early_dv), .early_data(early_data),
        .gate_en(gate_en), .speed_100(speed_100), .loopback(loopback),
        .pcs_bypass(pcs_bypass), .clk_en(clk_en), .rx_dv(rx_dv), .rx_data(rx_data)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_dv_q = {1'b0};
        m_dq = {'0};
        m_rx_dv = 1'b0;
        m_rx_data = '0;
        m_en = 1'b1;
        m_quiet = HANG + 1;
    endtask

    task automatic model_edge();
        bit act;
        act = gate_en && speed_100 && !loopback && !pcs_bypass;
        m_dv_q.push_back(early_dv);
        m_dq.push_back(early_data);
        m_rx_dv = m_dv_q.pop_front();
        m_rx_data = m_dq.pop_front();
        if (m_rx_dv) m_quiet = 0;
        else if (m_quiet <= HANG) m_quiet++;
        m_en = !act || early_dv || (m_quiet <= HANG);
    endtask

    task automatic cycle();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check(clk_en === m_en, phase, "clk_en", clk_en, m_en);
        check(rx_dv === m_rx_dv, phase, "rx_dv", rx_dv, m_rx_dv);
        check(rx_data === m_rx_data, phase, "rx_data", rx_data, m_rx_data);
    endtask

    task automatic idle(input int n);
        early_dv = 1'b0;
        for (int i = 0; i < n; i++) cycle();
    endtask

    task automatic frame(input int len);
        for (int i = 0; i < len; i++) begin
            early_dv = 1'b1;
            early_data = DW'($urandom);
            cycle();
        end
        early_dv = 1'b0;
    endtask

    initial begin
        int lows;
        int hang;
        logic [DW-1:0] first;
        model_reset();
        repeat (3) @(negedge clk);
        check(clk_en === 1'b1, "R6", "reset clk_en", clk_en, 1);
        check(rx_dv === 1'b0, "R6", "reset rx_dv", rx_dv, 0);
        check(rx_data === '0, "R6", "reset rx_data", rx_data, 0);
        rst_n = 1'b1;

        phase = "R10";
        speed_100 = 1'b1;
        idle(5);
        frame(6);
        idle(10);
        check(clk_en === 1'b1, "R10", "disabled idle runs", clk_en, 1);

        phase = "R2";
        gate_en = 1'b1;
        idle(80);
        check(clk_en === 1'b0, "R2", "gated idle low", clk_en, 0);

        phase = "R3";
        early_dv = 1'b1;
        first = 4'hA;
        early_data = first;
        cycle();
        check(clk_en === 1'b1 && rx_dv === 1'b0, "R3", "enable leads dv", clk_en, 1);
        early_data = 4'h5;
        cycle();
        check(rx_dv === 1'b1, "R8", "dv two edges later", rx_dv, 1);
        check(rx_data === first, "R8", "first nibble", rx_data, first);
        frame(18);

        phase = "R4";
        hang = 0;
        for (int i = 0; i < 200; i++) begin
            cycle();
            if (!clk_en) break;
            if (!rx_dv) hang++;
        end
        check(hang == HANG, "R4", "hangover length", hang, HANG);
        idle(5);

        phase = "R9";
        frame(10);
        lows = 0;
        for (int i = 0; i < 30; i++) begin
            cycle();
            if (!clk_en) lows++;
        end
        frame(10);
        check(lows == 0, "R9", "no gap on reassert", lows, 0);
        idle(HANG + 10);

        phase = "R1";
        speed_100 = 1'b0;
        lows = 0;
        for (int i = 0; i < 80; i++) begin
            cycle();
            if (!clk_en) lows++;
        end
        check(lows == 0, "R1", "10M mode runs", lows, 0);
        speed_100 = 1'b1;
        idle(3);
        check(clk_en === 1'b0, "R2", "gated again", clk_en, 0);

        phase = "R5";
        loopback = 1'b1;
        cycle();
        check(clk_en === 1'b1, "R5", "loopback runs", clk_en, 1);
        idle(70);
        check(clk_en === 1'b1, "R5", "loopback stays on", clk_en, 1);
        loopback = 1'b0;
        idle(3);

        phase = "R7";
        pcs_bypass = 1'b1;
        cycle();
        check(clk_en === 1'b1, "R7", "bypass runs", clk_en, 1);
        idle(70);
        check(clk_en === 1'b1, "R7", "bypass stays on", clk_en, 1);
        pcs_bypass = 1'b0;
        idle(3);

        phase = "R10";
        check(clk_en === 1'b0, "R10", "stopped before disable", clk_en, 0);
        gate_en = 1'b0;
        cycle();
        check(clk_en === 1'b1, "R10", "disable runs next cycle", clk_en, 1);
        idle(5);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired in phase %s actual=0 expected=1", phase);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule